// File: doc/BRIEF.md
# Pulse-Width Downlink Decoder with Preamble Gate

This block turns the digitized on/off envelope of a reader-to-tag link into message words. Each bit is one pulse-width symbol. A symbol starts at a rising edge and ends at the next rising edge. The block times that interval with the system clock and also counts how many cycles the line was high. It then sorts the symbol into 0, 1 or bad, from the ratio of high time to period. The default timing assumes 80 clock cycles per nominal bit, which fits a 100 kb/s link on an 8 MHz clock. A reader typically sends about 40% high for a 0 and about 75% high for a 1.

The detector output is noisy while the link is idle. For this reason, no payload is collected until a full 16-bit sync word has arrived as an unbroken run of good symbols. Payload bits are then shifted in. When the word is complete, the word is presented together with a one-cycle valid strobe, and the decoder starts searching for the sync word again. Any symbol with the wrong timing raises a one-cycle error strobe and throws away the partial frame.

The final symbol of a frame is closed by the rising edge of the pulse that follows it. A transmitter therefore ends each frame with a short closing pulse.

Top module: `pwmdl_top`

## Requirements
- R1: While `rst_n` is low and after it is released, `msg_valid` and `msg_err` are 0 and `msg_data` is 0.
- R2: The input passes through two synchronizing flops. The symbol period is the number of cycles from one synchronized rising edge to the next, and the high time is the number of those cycles in which the line is high. If the high time is below LO_PCT (45) percent of the period, the symbol decodes as 0.
- R3: If the high time is above HI_PCT (55) percent of the period, the symbol decodes as 1.
- R4: If the high time lies from 45% to 55% of the period, inclusive, the symbol is bad. `msg_err` pulses for one cycle and the decoder drops back to sync search. `msg_valid` and `msg_err` are never high in the same cycle.
- R5: A period is accepted only if it lies between 3/4 and 5/4 of CLKS_PER_BIT, inclusive (60 to 100 cycles by default). A period outside that range makes the symbol bad, with the same effect as R4.
- R6: Payload collection begins only when the last PRE_BITS good symbols, with no bad symbol or timeout between them, equal PREAMBLE (default 16'hB38F). The earliest symbol of the run is compared with the most significant bit.
- R7: After MSG_BITS payload symbols, `msg_valid` is high for exactly one cycle. At that point `msg_data` holds the payload, with the first payload symbol in the most significant bit.
- R8: `msg_data` changes only in a cycle in which `msg_valid` is high.
- R9: If no rising edge arrives within 5/4 of CLKS_PER_BIT cycles during payload collection, `msg_err` pulses and the frame is dropped. Noise pulses whose periods are all out of range never produce `msg_valid`.
- R10: After a completed message the decoder searches for the sync word again, so a second payload that is not preceded by its own sync word is not delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| env_in | input | 1 | Digitized envelope, asynchronous to `clk` |
| msg_data | output | MSG_BITS | Last completed payload, first symbol in the MSB |
| msg_valid | output | 1 | One-cycle strobe when a payload completes |
| msg_err | output | 1 | One-cycle strobe on a bad symbol or a payload timeout |

## Verification
The assertions assume that `env_in` is either a clean run of pulse-width symbols or idle noise. They also assume that a frame's last symbol is always followed by a closing rising edge. Under these assumptions each timing fault results in exactly one error strobe. The stimulus changes `env_in` only on falling clock edges and builds every symbol from whole cycles of high and low time. As a result, the measured period and high time equal the values the bench intended, and the duty limits can be hit exactly. The idle-noise pattern is generated so that every period falls well below or well above the accepted window. This makes the absence of `msg_valid` a firm expectation rather than a statistical one.

// File: rtl/pwmdl_pkg.sv
package pwmdl_pkg;
    typedef enum logic {
        FR_SEARCH  = 1'b0,
        FR_PAYLOAD = 1'b1
    } fr_state_e;

    localparam int unsigned PCT_SCALE = 100;
endpackage

// File: rtl/pwmdl_sync.sv
module pwmdl_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d = {pipe_q[STAGES-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    assign dout = pipe_q[STAGES-1];
endmodule

// File: rtl/pwmdl_meter.sv
module pwmdl_meter #(
    parameter int unsigned PER_MAX = 100,
    parameter int unsigned W       = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sig,
    output logic         sym_stb,
    output logic [W-1:0] sym_per,
    output logic [W-1:0] sym_hi,
    output logic         tmo_stb
);
    typedef struct packed {
        logic         prev;
        logic         armed;
        logic [W-1:0] per;
        logic [W-1:0] hi;
        logic         stb;
        logic [W-1:0] per_out;
        logic [W-1:0] hi_out;
        logic         tmo;
    } meter_t;

    meter_t m_d, m_q;
    logic   rise;

    always_comb begin
        m_d      = m_q;
        m_d.stb  = 1'b0;
        m_d.tmo  = 1'b0;
        m_d.prev = sig;
        rise     = sig & ~m_q.prev;
        if (rise) begin
            if (m_q.armed) begin
                m_d.stb     = 1'b1;
                m_d.per_out = m_q.per;
                m_d.hi_out  = m_q.hi;
            end
            m_d.armed = 1'b1;
            m_d.per   = W'(1);
            m_d.hi    = W'(1);
        end else begin
            if (m_q.per <= W'(PER_MAX))          m_d.per = m_q.per + W'(1);
            if (sig && m_q.hi <= W'(PER_MAX))    m_d.hi  = m_q.hi + W'(1);
            if (m_q.armed && m_q.per > W'(PER_MAX)) begin
                m_d.armed = 1'b0;
                m_d.tmo   = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) m_q <= '0;
        else        m_q <= m_d;
    end

    assign sym_stb = m_q.stb;
    assign sym_per = m_q.per_out;
    assign sym_hi  = m_q.hi_out;
    assign tmo_stb = m_q.tmo;

    // R2: a symbol is only reported after the synchronized line was seen high
    p_rise_before_sym_r2: assert property (@(posedge clk) disable iff (!rst_n)
        m_q.stb |-> $past(sig));
endmodule

// File: rtl/pwmdl_classify.sv
module pwmdl_classify
    import pwmdl_pkg::*;
#(
    parameter int unsigned PER_MIN = 60,
    parameter int unsigned PER_MAX = 100,
    parameter int unsigned LO_PCT  = 45,
    parameter int unsigned HI_PCT  = 55,
    parameter int unsigned W       = 7
) (
    input  logic [W-1:0] per,
    input  logic [W-1:0] hi,
    output logic         bit_val,
    output logic         bad
);
    logic [31:0] hi_scaled, lo_lim, hi_lim;
    logic        per_ok;

    always_comb begin
        hi_scaled = 32'(hi) * 32'(PCT_SCALE);
        lo_lim    = 32'(per) * 32'(LO_PCT);
        hi_lim    = 32'(per) * 32'(HI_PCT);
        per_ok    = (32'(per) >= 32'(PER_MIN)) && (32'(per) <= 32'(PER_MAX));
        bit_val   = hi_scaled > hi_lim;
        bad       = !per_ok || ((hi_scaled >= lo_lim) && (hi_scaled <= hi_lim));
    end
endmodule

// File: rtl/pwmdl_framer.sv
module pwmdl_framer
    import pwmdl_pkg::*;
#(
    parameter int unsigned          PRE_BITS = 16,
    parameter logic [PRE_BITS-1:0]  PREAMBLE = 16'hB38F,
    parameter int unsigned          MSG_BITS = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sym_stb,
    input  logic                sym_bit,
    input  logic                sym_bad,
    input  logic                tmo_stb,
    output logic [MSG_BITS-1:0] msg_data,
    output logic                msg_valid,
    output logic                msg_err
);
    localparam int unsigned FW = $clog2(PRE_BITS + 1);
    localparam int unsigned CW = $clog2(MSG_BITS + 1);

    typedef struct packed {
        fr_state_e           st;
        logic [FW-1:0]       fill;
        logic [PRE_BITS-1:0] win;
        logic [CW-1:0]       cnt;
        logic [MSG_BITS-1:0] shf;
        logic [MSG_BITS-1:0] data;
        logic                valid;
        logic                err;
    } frame_t;

    frame_t f_d, f_q;

    always_comb begin
        f_d       = f_q;
        f_d.valid = 1'b0;
        f_d.err   = 1'b0;
        if (sym_stb) begin
            if (sym_bad) begin
                f_d.err  = 1'b1;
                f_d.st   = FR_SEARCH;
                f_d.fill = '0;
                f_d.cnt  = '0;
            end else if (f_q.st == FR_SEARCH) begin
                f_d.win = {f_q.win[PRE_BITS-2:0], sym_bit};
                if (f_q.fill < FW'(PRE_BITS)) f_d.fill = f_q.fill + FW'(1);
                if (f_q.fill >= FW'(PRE_BITS - 1) && f_d.win == PREAMBLE) begin
                    f_d.st   = FR_PAYLOAD;
                    f_d.fill = '0;
                    f_d.cnt  = '0;
                end
            end else begin
                f_d.shf = {f_q.shf[MSG_BITS-2:0], sym_bit};
                if (f_q.cnt == CW'(MSG_BITS - 1)) begin
                    f_d.data  = f_d.shf;
                    f_d.valid = 1'b1;
                    f_d.st    = FR_SEARCH;
                    f_d.cnt   = '0;
                end else begin
                    f_d.cnt = f_q.cnt + CW'(1);
                end
            end
        end else if (tmo_stb) begin
            if (f_q.st == FR_PAYLOAD) f_d.err = 1'b1;
            f_d.st   = FR_SEARCH;
            f_d.fill = '0;
            f_d.cnt  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    assign msg_data  = f_q.data;
    assign msg_valid = f_q.valid;
    assign msg_err   = f_q.err;

    p_bad_abort_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sym_stb && sym_bad) |=> (f_q.err && f_q.st == FR_SEARCH));

    p_no_both_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(f_q.valid && f_q.err));

    p_entry_after_preamble_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(f_q.st == FR_PAYLOAD) |-> ($past(f_q.fill) >= FW'(PRE_BITS - 1)));

    p_valid_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        f_q.valid |=> !f_q.valid);

    p_data_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !f_q.valid |-> $stable(f_q.data));

    p_timeout_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (tmo_stb && !sym_stb && f_q.st == FR_PAYLOAD) |=> f_q.err);

    p_resume_search_r10: assert property (@(posedge clk) disable iff (!rst_n)
        f_q.valid |-> (f_q.st == FR_SEARCH && f_q.fill == '0));
endmodule

// File: rtl/pwmdl_top.sv
module pwmdl_top #(
    parameter int unsigned         CLKS_PER_BIT = 80,
    parameter int unsigned         PRE_BITS     = 16,
    parameter logic [PRE_BITS-1:0] PREAMBLE     = 16'hB38F,
    parameter int unsigned         MSG_BITS     = 16,
    parameter int unsigned         LO_PCT       = 45,
    parameter int unsigned         HI_PCT       = 55
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                env_in,
    output logic [MSG_BITS-1:0] msg_data,
    output logic                msg_valid,
    output logic                msg_err
);
    localparam int unsigned PER_MIN = CLKS_PER_BIT - CLKS_PER_BIT / 4;
    localparam int unsigned PER_MAX = CLKS_PER_BIT + CLKS_PER_BIT / 4;
    localparam int unsigned W       = $clog2(PER_MAX + 2);

    logic         env_s;
    logic         sym_stb, tmo_stb, sym_bit, sym_bad;
    logic [W-1:0] sym_per, sym_hi;

    pwmdl_sync #(.STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(env_in), .dout(env_s)
    );

    pwmdl_meter #(.PER_MAX(PER_MAX), .W(W)) u_meter (
        .clk(clk), .rst_n(rst_n), .sig(env_s),
        .sym_stb(sym_stb), .sym_per(sym_per), .sym_hi(sym_hi), .tmo_stb(tmo_stb)
    );

    pwmdl_classify #(
        .PER_MIN(PER_MIN), .PER_MAX(PER_MAX),
        .LO_PCT(LO_PCT), .HI_PCT(HI_PCT), .W(W)
    ) u_class (
        .per(sym_per), .hi(sym_hi), .bit_val(sym_bit), .bad(sym_bad)
    );

    pwmdl_framer #(
        .PRE_BITS(PRE_BITS), .PREAMBLE(PREAMBLE), .MSG_BITS(MSG_BITS)
    ) u_framer (
        .clk(clk), .rst_n(rst_n),
        .sym_stb(sym_stb), .sym_bit(sym_bit), .sym_bad(sym_bad), .tmo_stb(tmo_stb),
        .msg_data(msg_data), .msg_valid(msg_valid), .msg_err(msg_err)
    );
endmodule

// File: tb/tb_pwmdl_top.sv
module tb_pwmdl_top;
    localparam logic [15:0] PRE = 16'hB38F;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        env_in = 1'b0;
    logic [15:0] msg_data;
    logic        msg_valid, msg_err;

    int checks = 0;
    int failures = 0;
    int valid_cnt = 0;
    int err_cnt = 0;
    logic [15:0] last_data = '0;
    logic [15:0] lfsr = 16'hACE1;
    bit   wide = 1'b0;
    bit   done = 1'b0;

    always #4 clk = ~clk;

    pwmdl_top dut (
        .clk(clk), .rst_n(rst_n), .env_in(env_in),
        .msg_data(msg_data), .msg_valid(msg_valid), .msg_err(msg_err)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (msg_valid) begin
                valid_cnt++;
                last_data = msg_data;
            end
            if (msg_err) err_cnt++;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic sym(input int hi, input int per);
        env_in = 1'b1;
        repeat (hi) @(negedge clk);
        env_in = 1'b0;
        repeat (per - hi) @(negedge clk);
    endtask

    task automatic send_bit(input logic b);
        if (b) sym(60, 80);
        else   sym(32, 80);
    endtask

    task automatic send_word(input logic [15:0] w);
        for (int i = 15; i >= 0; i--) send_bit(w[i]);
    endtask

    // alternates 62-cycle and 98-cycle periods with duties just outside the dead band
    task automatic send_edge_word(input logic [15:0] w);
        for (int i = 15; i >= 0; i--) begin
            if (wide) sym(w[i] ? 56 : 42, 98);
            else      sym(w[i] ? 36 : 26, 62);
            wide = ~wide;
        end
    endtask

    task automatic close_frame();
        sym(4, 250);
    endtask

    task automatic t_reset();
        check("R1", {31'd0, msg_valid}, 0, "valid after reset");
        check("R1", {31'd0, msg_err}, 0, "err after reset");
        check("R1", {16'd0, msg_data}, 0, "data after reset");
    endtask

    task automatic t_nominal();
        int v0 = valid_cnt, e0 = err_cnt;
        send_word(PRE); send_word(16'hC35A); close_frame();
        check("R7", valid_cnt - v0, 1, "nominal message count");
        check("R2", {16'd0, last_data}, 32'hC35A, "nominal payload bits (R3)");
        check("R7", err_cnt - e0, 0, "nominal no error");
    endtask

    task automatic t_edges();
        int v0 = valid_cnt;
        send_edge_word(PRE); send_edge_word(16'h6E19); close_frame();
        check("R5", valid_cnt - v0, 1, "boundary periods accepted");
        check("R3", {16'd0, last_data}, 32'h6E19, "boundary duties decoded (R2)");
    endtask

    task automatic t_no_preamble();
        int v0 = valid_cnt;
        send_word(16'h0000); send_word(16'h0000); close_frame();
        check("R6", valid_cnt - v0, 0, "payload without sync word");
        send_word(PRE ^ 16'h0100); send_word(16'h0000); close_frame();
        check("R6", valid_cnt - v0, 0, "corrupted sync word");
    endtask

    task automatic t_deadband();
        int v0 = valid_cnt, e0 = err_cnt;
        send_word(PRE);
        for (int i = 0; i < 5; i++) send_bit(i[0]);
        sym(40, 80);
        close_frame();
        check("R4", valid_cnt - v0, 0, "dead band drops frame");
        check("R4", {31'd0, (err_cnt - e0) >= 1}, 1, "dead band flags error");
        send_word(PRE); send_word(16'h1234); close_frame();
        check("R4", {16'd0, last_data}, 32'h1234, "recovery after dead band");
    endtask

    task automatic t_period();
        int v0 = valid_cnt, e0 = err_cnt;
        send_word(PRE); send_bit(1); send_bit(0); send_bit(1);
        sym(20, 50);
        close_frame();
        check("R5", {31'd0, (err_cnt - e0) >= 1}, 1, "short period error");
        e0 = err_cnt;
        send_word(PRE); send_bit(0); send_bit(1); send_bit(1);
        sym(50, 120);
        close_frame();
        check("R5", {31'd0, (err_cnt - e0) >= 1}, 1, "long period error");
        check("R5", valid_cnt - v0, 0, "bad periods give no message");
    endtask

    task automatic t_noise();
        int v0 = valid_cnt;
        for (int i = 0; i < 300; i++) begin
            int per, hi;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (lfsr[0]) begin
                per = 3 + int'(lfsr[10:5]) % 38;
                hi  = 1 + per / 3;
            end else begin
                per = 130 + int'(lfsr[7:1]);
                hi  = 1 + int'(lfsr[12:9]);
            end
            sym(hi, per);
        end
        repeat (200) @(negedge clk);
        check("R9", valid_cnt - v0, 0, "idle noise gives no message");
        check("R8", {16'd0, msg_data}, 32'h1234, "data held through noise");
    endtask

    task automatic t_timeout();
        int v0 = valid_cnt, e0 = err_cnt;
        send_word(PRE);
        for (int i = 0; i < 8; i++) send_bit(i[1]);
        repeat (300) @(negedge clk);
        check("R9", err_cnt - e0, 1, "payload timeout error");
        check("R9", valid_cnt - v0, 0, "payload timeout no message");
    endtask

    task automatic t_back_to_back();
        int v0 = valid_cnt;
        send_word(PRE); send_word(16'h5AA5); send_word(16'h0F0F); close_frame();
        check("R10", valid_cnt - v0, 1, "second payload needs own sync");
        check("R10", {16'd0, last_data}, 32'h5AA5, "first payload kept");
        send_word(PRE); send_word(16'h9C01); close_frame();
        check("R10", valid_cnt - v0, 2, "new sync accepted");
        check("R8", {16'd0, msg_data}, 32'h9C01, "data updated with valid");
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        t_reset();
        t_nominal();
        t_edges();
        t_no_preamble();
        t_deadband();
        t_period();
        t_noise();
        t_timeout();
        t_back_to_back();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (180000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule